// File: doc/BRIEF.md
# Serial EEPROM Burst Word Reader

This block reads a run of consecutive 16-bit words from a three-wire serial EEPROM. It drives a select line, a serial clock and a data line into the memory, and samples the memory's data output. A host starts a burst with a one-cycle request that carries a start address, a word count and a byte-exchange flag. Each word is fetched in its own select frame. The frame sends an 11-bit header made of a 3-bit read opcode (binary 110, sent first) and an 8-bit word address. The block then clocks in 16 data bits.

Each finished word leaves the block on a one-cycle valid strobe, together with its position in the burst. The two bytes of the word are exchanged first if the host asked for that. A one-cycle done pulse closes the burst. The length of every serial clock phase is set in system clocks by a host input. That input is sampled when the burst starts, so slow memories can be served from a fast core clock.

Top module: `eeWordReader`

## Requirements
- R1: While reset is asserted and after it is released with no request, eeCs, eeSclk, eeDi, busy, wordValid and done are all 0.
- R2: Each select frame starts by sending 11 header bits MSB first, one per serial clock rise: the bits 1,1,0 followed by the 8-bit word address. eeDi is set during the low phase before each rise and stays stable while eeSclk is high.
- R3: Every high phase of eeSclk, and every low phase of eeSclk inside a select frame, lasts exactly max(phaseLen,1) system clocks, where phaseLen is sampled at the accepted request. eeSclk is never high while eeCs is low.
- R4: After the header, the frame gives exactly 16 more serial clock rises, 27 rises in all. Data bits are taken from eeDo MSB first, each sampled in the last system clock of a high phase.
- R5: After the last data bit, eeCs, eeSclk and eeDi all go to 0. Between two frames of a burst, eeCs stays low for at least max(phaseLen,1) system clocks. eeSclk and eeDi are 0 whenever eeCs is 0.
- R6: The word at burst position k is read from address (startOffset + k) modulo 256.
- R7: Each word appears as a one-cycle wordValid pulse, with the data on wordData and its 0-based position on wordIndex. The pulse comes in the first system clock after its frame's last high phase, and eeCs is already low in that clock. A burst of N words gives exactly N pulses, with indices 0 to N-1.
- R8: If swapBytes was 1 at the accepted request, wordData carries the low received byte in bits 15:8 and the high received byte in bits 7:0. If it was 0, the word is passed through unchanged.
- R9: done pulses for one cycle in the clock after the last frame's closing low-select interval, and busy is 0 in that same cycle. A request with wordCount 0 gives done in the clock after the request edge, with no select frame at all.
- R10: A startReq is ignored while busy is 1: the running burst keeps its parameters and word count, and no further frame or wordValid follows its done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle burst request, accepted only when idle |
| startOffset | input | 8 | Address of the first word |
| wordCount | input | 9 | Number of words to read (0 allowed) |
| swapBytes | input | 1 | Exchange the two bytes of every word |
| phaseLen | input | 8 | System clocks per serial clock phase (0 acts as 1) |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| wordValid | output | 1 | One-cycle word strobe |
| wordData | output | 16 | Received word, possibly byte-exchanged |
| wordIndex | output | 9 | Position of the word within the burst |
| eeCs | output | 1 | Memory select |
| eeSclk | output | 1 | Serial clock to the memory |
| eeDi | output | 1 | Serial data to the memory |
| eeDo | input | 1 | Serial data from the memory |

## Verification
The serial lines change in the system clock right after the phase counter wraps. Each phase therefore spans exactly max(phaseLen,1) clocks, and the bench measures every high phase, every in-frame low phase and every inter-frame gap in falling-edge samples. A word's strobe is due one clock after the last high phase of its frame, and it coincides with the first low-select clock. done is due one clock after the last gap, or one clock after the request edge when the count is zero. The bench therefore samples outputs on falling clock edges and checks done at exactly that offset for the empty burst. The bench's memory model updates eeDo half a system clock after each serial clock fall, so the value sampled at the end of a high phase is always settled.

// File: rtl/eeRdPkg.sv
package eeRdPkg;
  // read opcode sent ahead of the address, first bit first
  localparam logic [2:0] READ_OP = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_GAP,
    ST_FIN
  } eeStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBurst;
    logic shiftCmd;
    logic captureBit;
    logic emitWord;
    logic reloadCmd;
    logic driveCmd;
  } eeCtlT;
endpackage

// File: rtl/eeRdCtrl.sv
module eeRdCtrl
  import eeRdPkg::*;
#(
  parameter int CMD_W   = 11,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 9,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [CNT_W-1:0]   wordCount,
  input  logic [PHASE_W-1:0] phaseLen,
  output eeCtlT              ctl,
  output logic               eeCs,
  output logic               eeSclk,
  output logic               busy,
  output logic               done
);
  localparam int LAST_BIT = CMD_W + DATA_W - 1;
  localparam int BIT_W    = $clog2(LAST_BIT + 1);

  eeStateT            state;
  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] lastPhase;
  logic [BIT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   wordsLeft;
  logic               phaseEnd;
  logic               inFrame;
  logic               lastBit;

  assign phaseEnd = (phaseCnt == lastPhase);
  assign inFrame  = (state == ST_LO) || (state == ST_HI);
  assign lastBit  = (bitCnt == BIT_W'(LAST_BIT));

  always_comb begin
    ctl            = '0;
    ctl.loadBurst  = (state == ST_IDLE) && startReq;
    ctl.shiftCmd   = (state == ST_HI) && phaseEnd && (bitCnt < BIT_W'(CMD_W));
    ctl.captureBit = (state == ST_HI) && phaseEnd && (bitCnt >= BIT_W'(CMD_W));
    ctl.emitWord   = (state == ST_HI) && phaseEnd && lastBit;
    ctl.reloadCmd  = (state == ST_GAP) && phaseEnd && (wordsLeft != CNT_W'(1));
    ctl.driveCmd   = inFrame && (bitCnt < BIT_W'(CMD_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      lastPhase <= '0;
      bitCnt    <= '0;
      wordsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          lastPhase <= (phaseLen == '0) ? '0 : phaseLen - 1'b1;
          wordsLeft <= wordCount;
          bitCnt    <= '0;
          phaseCnt  <= '0;
          state     <= (wordCount == '0) ? ST_FIN : ST_LO;
        end
        ST_LO: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            state    <= ST_HI;
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        ST_HI: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (lastBit) begin
              bitCnt <= '0;
              state  <= ST_GAP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_LO;
            end
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        ST_GAP: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (wordsLeft == CNT_W'(1)) state <= ST_FIN;
            else begin
              wordsLeft <= wordsLeft - 1'b1;
              state     <= ST_LO;
            end
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign eeCs   = inFrame;
  assign eeSclk = (state == ST_HI);
  assign busy   = inFrame || (state == ST_GAP);
  assign done   = (state == ST_FIN);
endmodule

// File: rtl/eeRdPath.sv
module eeRdPath
  import eeRdPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 9,
  parameter int CMD_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeCtlT             ctl,
  input  logic [ADDR_W-1:0] startOffset,
  input  logic              swapBytes,
  input  logic              eeDo,
  output logic              eeDi,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [CNT_W-1:0]  wordIndex
);
  localparam int HALF = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] dataSh;
  logic [DATA_W-1:0] assembled;
  logic [DATA_W-1:0] swapped;
  logic [CNT_W-1:0]  idxCnt;
  logic              swapReg;

  assign assembled = {dataSh[DATA_W-2:0], eeDo};

  // byte exchange, one bit position at a time
  for (genvar b = 0; b < HALF; b++) begin : g_swap
    assign swapped[b]        = swapReg ? assembled[b + HALF] : assembled[b];
    assign swapped[b + HALF] = swapReg ? assembled[b]        : assembled[b + HALF];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      cmdReg    <= '0;
      dataSh    <= '0;
      idxCnt    <= '0;
      swapReg   <= 1'b0;
      wordValid <= 1'b0;
      wordData  <= '0;
      wordIndex <= '0;
    end else begin
      wordValid <= 1'b0;
      if (ctl.loadBurst) begin
        cmdReg  <= {READ_OP, startOffset};
        addrReg <= startOffset + 1'b1;
        swapReg <= swapBytes;
        idxCnt  <= '0;
      end
      if (ctl.shiftCmd)   cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
      if (ctl.captureBit) dataSh <= assembled;
      if (ctl.emitWord) begin
        wordValid <= 1'b1;
        wordData  <= swapped;
        wordIndex <= idxCnt;
        idxCnt    <= idxCnt + 1'b1;
      end
      if (ctl.reloadCmd) begin
        cmdReg  <= {READ_OP, addrReg};
        addrReg <= addrReg + 1'b1;
      end
    end
  end

  assign eeDi = ctl.driveCmd & cmdReg[CMD_W-1];
endmodule

// File: rtl/eeWordReader.sv
module eeWordReader
  import eeRdPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 9,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [ADDR_W-1:0]  startOffset,
  input  logic [CNT_W-1:0]   wordCount,
  input  logic               swapBytes,
  input  logic [PHASE_W-1:0] phaseLen,
  output logic               busy,
  output logic               done,
  output logic               wordValid,
  output logic [DATA_W-1:0]  wordData,
  output logic [CNT_W-1:0]   wordIndex,
  output logic               eeCs,
  output logic               eeSclk,
  output logic               eeDi,
  input  logic               eeDo
);
  localparam int CMD_W = ADDR_W + $bits(READ_OP);

  eeCtlT ctl;

  eeRdCtrl #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PHASE_W(PHASE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordCount(wordCount),
    .phaseLen(phaseLen), .ctl(ctl), .eeCs(eeCs), .eeSclk(eeSclk),
    .busy(busy), .done(done)
  );

  eeRdPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CMD_W(CMD_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startOffset(startOffset),
    .swapBytes(swapBytes), .eeDo(eeDo), .eeDi(eeDi), .wordValid(wordValid),
    .wordData(wordData), .wordIndex(wordIndex)
  );
endmodule

// File: rtl/eeWordReaderChk.sv
module eeWordReaderChk (
  input logic clk,
  input logic rstN,
  input logic eeCs,
  input logic eeSclk,
  input logic eeDi,
  input logic busy,
  input logic done,
  input logic wordValid
);
  assert_di_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (eeSclk && $past(eeSclk)) |-> $stable(eeDi));

  assert_clk_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    eeSclk |-> eeCs);

  assert_idle_lines_R5: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> (!eeSclk && !eeDi));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_valid_in_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (!eeCs && busy));

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_frame_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    eeCs |-> busy);
endmodule

bind eeWordReader eeWordReaderChk u_chk (
  .clk(clk), .rstN(rstN), .eeCs(eeCs), .eeSclk(eeSclk), .eeDi(eeDi),
  .busy(busy), .done(done), .wordValid(wordValid)
);

// File: tb/eeWordReader_bench.sv
`timescale 1ns/1ps
module eeWordReader_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  startOffset = '0;
  logic [8:0]  wordCount = '0;
  logic        swapBytes = 1'b0;
  logic [7:0]  phaseLen = 8'd1;
  logic        busy, done, wordValid, eeCs, eeSclk, eeDi;
  logic        eeDo = 1'b0;
  logic [15:0] wordData;
  logic [8:0]  wordIndex;

  always #2.5 clk = ~clk;

  eeWordReader u_eeWordReader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startOffset(startOffset),
    .wordCount(wordCount), .swapBytes(swapBytes), .phaseLen(phaseLen),
    .busy(busy), .done(done), .wordValid(wordValid), .wordData(wordData),
    .wordIndex(wordIndex), .eeCs(eeCs), .eeSclk(eeSclk), .eeDi(eeDi),
    .eeDo(eeDo)
  );

  int vectors = 0;
  int fails = 0;
  bit reported = 0;

  // expectations of the running burst
  logic [7:0] expOff;
  int expCnt, expP, gotIdx, mWord;
  bit expSwap, inBurst = 0;

  // model and monitor state
  logic [10:0] mCmd = '0;
  int rises = 0, hiRun = 0, loRun = 0, csLow = 0;
  logic prevSclk = 1'b0, prevCs = 1'b0;

  function automatic logic [15:0] memWord(input logic [7:0] a);
    logic [7:0] lo;
    lo = 8'(a * 8'd7 + 8'd1);
    return {a ^ 8'hC3, lo};
  endfunction

  function automatic logic [15:0] expWord(input logic [7:0] a, input bit sw);
    logic [15:0] w;
    w = memWord(a);
    return sw ? {w[7:0], w[15:8]} : w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    end
  endtask

  // memory model and line monitor, sampled on falling system clock edges
  always @(negedge clk) begin
    logic [15:0] w;
    if (eeCs && !prevCs) begin
      rises = 0;
      if (inBurst && mWord > 0) chk(csLow >= expP, "R5 gap", csLow, expP);
      csLow = 0;
    end
    if (!eeCs) csLow++;
    if (eeSclk && !prevSclk) begin
      if (rises < 11) mCmd = {mCmd[9:0], eeDi};
      rises++;
      chk(loRun == expP, "R3 low phase", loRun, expP);
      loRun = 0;
    end
    if (!eeSclk && prevSclk && eeCs && rises >= 11 && rises <= 26) begin
      w = memWord(mCmd[7:0]);
      eeDo <= w[26 - rises];
    end
    if (eeSclk) hiRun++;
    else if (hiRun != 0) begin
      chk(hiRun == expP, "R3 high phase", hiRun, expP);
      hiRun = 0;
    end
    if (eeCs && !eeSclk) loRun++;
    if (!eeCs && prevCs) begin
      loRun = 0;
      chk(mCmd[10:8] == 3'b110, "R2 opcode", int'(mCmd[10:8]), 6);
      chk(mCmd[7:0] == 8'(expOff + mWord), "R6 address", int'(mCmd[7:0]),
          int'(8'(expOff + mWord)));
      chk(rises == 27, "R4 clock count", rises, 27);
      mWord++;
    end
    if (wordValid) begin
      if (!inBurst) chk(0, "R10 stray word", int'(wordData), 0);
      else begin
        chk(wordData == expWord(8'(expOff + gotIdx), expSwap),
            expSwap ? "R8 swapped data" : "R4 R8 data", int'(wordData),
            int'(expWord(8'(expOff + gotIdx), expSwap)));
        chk(int'(wordIndex) == gotIdx, "R7 index", int'(wordIndex), gotIdx);
        chk(!eeCs, "R7 select low at strobe", int'(eeCs), 0);
        gotIdx++;
      end
    end
    prevSclk = eeSclk;
    prevCs   = eeCs;
  end

  task automatic runBurst(input logic [7:0] off, input int cnt, input bit sw,
                          input logic [7:0] p, input bit intrude);
    int waited;
    expOff = off; expCnt = cnt; expSwap = sw;
    expP = (p == 0) ? 1 : int'(p);
    gotIdx = 0; mWord = 0; inBurst = 1;
    @(negedge clk);
    startOffset = off; wordCount = 9'(cnt); swapBytes = sw; phaseLen = p;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waited = 0;
    while (!done && waited < 40000) begin
      @(negedge clk);
      waited++;
      if (intrude && waited == 100) begin
        startOffset = 8'h80; wordCount = 9'd5; swapBytes = ~sw; phaseLen = 8'd2;
        startReq = 1'b1;
      end else if (intrude && waited == 101) startReq = 1'b0;
    end
    chk(done, "R9 done seen", int'(done), 1);
    chk(!busy, "R9 busy low with done", int'(busy), 0);
    chk(gotIdx == cnt, intrude ? "R10 word count" : "R7 word count", gotIdx, cnt);
    chk(mWord == cnt, "R6 frame count", mWord, cnt);
    if (cnt == 0) chk(waited == 0, "R9 empty burst timing", waited, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
    inBurst = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({eeCs, eeSclk, eeDi, busy, wordValid, done} == 6'b0, "R1 in reset",
        int'({eeCs, eeSclk, eeDi, busy, wordValid, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk({eeCs, eeSclk, eeDi, busy, wordValid, done} == 6'b0, "R1 after reset",
        int'({eeCs, eeSclk, eeDi, busy, wordValid, done}), 0);

    // directed corners
    runBurst(8'hFE, 4, 0, 8'd1, 0);  // R6 address wrap
    runBurst(8'h10, 3, 1, 8'd3, 0);  // R8 swap
    runBurst(8'h44, 2, 0, 8'd0, 0);  // R3 phaseLen 0 acts as 1
    runBurst(8'h55, 0, 1, 8'd2, 0);  // R9 empty burst
    runBurst(8'h20, 2, 0, 8'd2, 1);  // R10 request while busy
    repeat (300) @(negedge clk);
    chk(!busy && !eeCs, "R10 no extra burst", int'({busy, eeCs}), 0);

    // random bursts
    for (int i = 0; i < 8; i++) begin
      runBurst(8'($urandom % 256), 1 + int'($urandom % 5), bit'($urandom % 2),
               8'(1 + $urandom % 4), 0);
    end
    report();
    $finish;
  end
endmodule